// File: doc/BRIEF.md
# Register-Compare Byte Processor Core

This block is a small multi-cycle processor with four 8-bit general registers, a 16-bit instruction pointer and a 16-bit return pointer. It runs a 16-opcode instruction set. Each instruction is one byte. Instructions that carry an address are followed by two more bytes that hold that address, high byte first. There is no flags register. Conditional branches and conditional calls compare two general registers directly. A call pushes its return address into a small internal return RAM indexed by the return pointer. The pointer starts just below a reserved device window and moves down by one per push.

The core works with a byte-wide synchronous memory: read data appears on the cycle after a read strobe. The top sixteen addresses never reach that memory. The highest address is a character port. A load from it takes a byte from an input stream and a store to it sends a byte on an output stream. Both streams use valid/ready. The core raises `in_ready` and waits for as long as `in_valid` is low. It holds `out_valid` and `out_data` steady until `out_ready` is seen. A byte moves only in a cycle where valid and ready are both high. The other reserved addresses read as zero and ignore writes. A halt instruction stops the core until the next reset.

Top module: `rc_core`

## Requirements
- R1: While reset is held and in the first cycle after it, the core issues a read of address 0 with no write, and `halted` is low. The return pointer starts at 0xFFF0.
- R2: An instruction byte carries the opcode in bits 7:4, register X in bits 3:2 and register Y in bits 1:0. Opcodes 0xA to 0xF are followed by a 16-bit address, high byte first. The opcodes are 0 halt, 1 return, 2 SHL, 3 SHR, 4 ROL, 5 ROR, 6 NAND, 7 AND, 8 OR, 9 XOR, A load, B store, C branch-if-equal, D branch-if-not-equal, E call-if-equal, F call-if-not-equal.
- R3: SHL and SHR shift RX by one bit and fill with zero. ROL and ROR rotate RX by one bit, and the bit that leaves one end enters the other.
- R4: NAND writes ~(RX & RY) to RX. AND, OR and XOR write RX op RY to RX.
- R5: A load below 0xFFF0 copies the addressed memory byte into RX. A store below 0xFFF0 writes RX to memory.
- R6: A load from 0xFFFF raises `in_ready` and stalls until `in_valid`. It then writes `in_data` into RX and consumes exactly one input byte.
- R7: A store to 0xFFFF raises `out_valid` with RX on `out_data`. Both hold until `out_ready`, and exactly one byte is sent.
- R8: Addresses 0xFFF0 to 0xFFFE never appear on the memory bus with a strobe. Loads from them return 0 and stores to them have no effect.
- R9: A branch loads IP with its address only when its condition on RX and RY holds. Otherwise execution continues after the 3-byte instruction.
- R10: A taken call decrements RP and stores the address after the 3-byte call at the new RP, then jumps. A return reloads IP from the entry at RP and increments RP. RP changes by exactly one when it changes.
- R11: HALT raises `halted`, which stays high with no memory strobe until reset.
- R12: The read and write strobes are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mem_addr | output | 16 | Memory address |
| mem_rd | output | 1 | Read strobe; data is returned the next cycle |
| mem_wr | output | 1 | Write strobe |
| mem_wdata | output | 8 | Write data |
| mem_rdata | input | 8 | Read data, one cycle after `mem_rd` |
| in_valid | input | 1 | Input byte available |
| in_ready | output | 1 | Core is waiting on an input byte |
| in_data | input | 8 | Input byte |
| out_valid | output | 1 | Output byte available |
| out_ready | input | 1 | Sink accepts the output byte |
| out_data | output | 8 | Output byte |
| halted | output | 1 | Core has stopped |

## Verification
A corrupted general register shows up at the next store or port write that uses it. It shows up sooner if it flips a branch or call decision, which sends the fetch stream to the wrong address within one instruction. A wrong return pointer or return entry appears at the next return, as a fetch from an unexpected address, and then as missing or extra port output. A fault in the fetch state sequence misaligns the operand bytes. That produces strobes in the reserved window or stores in the wrong place within a few instructions, and it is caught when the final memory image and the output stream are compared with an instruction-level model.

// File: rtl/rc_pkg.sv
package rc_pkg;
  typedef enum logic [3:0] {
    OP_HALT = 4'h0, OP_RET, OP_SHL, OP_SHR, OP_ROL, OP_ROR,
    OP_NAND, OP_AND, OP_OR, OP_XOR, OP_LOAD, OP_STORE,
    OP_BREQ, OP_BRNE, OP_CALEQ, OP_CALNE
  } opc_e;

  typedef enum logic [2:0] {
    ST_FETCH, ST_OPC, ST_ADHI, ST_ADLO, ST_EXEC, ST_LDWB, ST_HALT
  } state_e;

  // opcodes 0xA..0xF carry a two-byte address operand
  function automatic logic has_addr(logic [3:0] code);
    return code[3] & (code[2] | code[1]);
  endfunction
endpackage

// File: rtl/rc_alu.sv
module rc_alu
  import rc_pkg::*;
#(
  parameter int DW = 8
) (
  input  opc_e          op,
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  output logic [DW-1:0] res
);
  always_comb begin
    case (op)
      OP_SHL:  res = {a[DW-2:0], 1'b0};
      OP_SHR:  res = {1'b0, a[DW-1:1]};
      OP_ROL:  res = {a[DW-2:0], a[DW-1]};
      OP_ROR:  res = {a[0], a[DW-1:1]};
      OP_NAND: res = ~(a & b);
      OP_AND:  res = a & b;
      OP_OR:   res = a | b;
      OP_XOR:  res = a ^ b;
      default: res = a;
    endcase
  end

  always_comb begin
    // R3
    if (op == OP_ROL || op == OP_ROR)
      rot_popcount_chk: assert ($countones(res) == $countones(a));
  end
endmodule

// File: rtl/rc_regfile.sv
module rc_regfile #(
  parameter int DW   = 8,
  parameter int NREG = 4,
  localparam int IW  = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [IW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [IW-1:0] ra,
  input  logic [IW-1:0] rb,
  output logic [DW-1:0] rdata_a,
  output logic [DW-1:0] rdata_b
);
  logic [NREG-1:0][DW-1:0] bank;

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    logic [DW-1:0] val;
    always_ff @(posedge clk) begin
      if (we && waddr == IW'(i)) val <= wdata;
    end
    assign bank[i] = val;
  end

  assign rdata_a = bank[ra];
  assign rdata_b = bank[rb];
endmodule

// File: rtl/rc_retstack.sv
module rc_retstack #(
  parameter int AW   = 16,
  parameter int DLOG = 4,
  localparam int DEPTH = 1 << DLOG
) (
  input  logic            clk,
  input  logic            we,
  input  logic [DLOG-1:0] waddr,
  input  logic [AW-1:0]   wdata,
  input  logic [DLOG-1:0] raddr,
  output logic [AW-1:0]   rdata
);
  logic [AW-1:0] ram [DEPTH];

  always_ff @(posedge clk) begin
    if (we) ram[waddr] <= wdata;
  end

  assign rdata = ram[raddr];
endmodule

// File: rtl/rc_core.sv
module rc_core
  import rc_pkg::*;
#(
  parameter int DW     = 8,
  parameter int AW     = 16,
  parameter int NREG   = 4,
  parameter int RS_LOG = 4,
  parameter logic [AW-1:0] DEV_BASE  = 16'hFFF0,
  parameter logic [AW-1:0] PORT_ADDR = 16'hFFFF,
  parameter logic [AW-1:0] RP_START  = 16'hFFF0
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic [AW-1:0] mem_addr,
  output logic          mem_rd,
  output logic          mem_wr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [DW-1:0] in_data,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [DW-1:0] out_data,
  output logic          halted
);
  localparam int RIW = $clog2(NREG);

  state_e        st;
  logic [AW-1:0] ip, rp, opaddr;
  logic [DW-1:0] ir;
  opc_e          op;
  logic [RIW-1:0] fx, fy;
  logic [DW-1:0] rx, ry, alu_res, rf_wd;
  logic          rf_we, rs_we, is_port, is_dev, eq, cond;
  logic [AW-1:0] rs_rdata, rp_dec;

  assign op      = opc_e'(ir[DW-1:DW-4]);
  assign fx      = ir[2*RIW-1:RIW];
  assign fy      = ir[RIW-1:0];
  assign is_port = (opaddr == PORT_ADDR);
  assign is_dev  = (opaddr >= DEV_BASE);
  assign eq      = (rx == ry);
  assign cond    = op[0] ? !eq : eq;
  assign rp_dec  = rp - AW'(1);

  rc_regfile #(.DW(DW), .NREG(NREG)) rf_i (
    .clk(clk), .we(rf_we), .waddr(fx), .wdata(rf_wd),
    .ra(fx), .rb(fy), .rdata_a(rx), .rdata_b(ry)
  );

  rc_alu #(.DW(DW)) alu_i (.op(op), .a(rx), .b(ry), .res(alu_res));

  rc_retstack #(.AW(AW), .DLOG(RS_LOG)) rs_i (
    .clk(clk), .we(rs_we), .waddr(rp_dec[RS_LOG-1:0]), .wdata(ip),
    .raddr(rp[RS_LOG-1:0]), .rdata(rs_rdata)
  );

  always_comb begin
    mem_rd    = 1'b0;
    mem_wr    = 1'b0;
    mem_addr  = ip;
    mem_wdata = rx;
    in_ready  = 1'b0;
    out_valid = 1'b0;
    rf_we     = 1'b0;
    rf_wd     = alu_res;
    rs_we     = 1'b0;
    case (st)
      ST_FETCH: mem_rd = 1'b1;
      ST_OPC:   mem_rd = has_addr(mem_rdata[DW-1:DW-4]);
      ST_ADHI:  mem_rd = 1'b1;
      ST_EXEC: begin
        case (op)
          OP_SHL, OP_SHR, OP_ROL, OP_ROR,
          OP_NAND, OP_AND, OP_OR, OP_XOR: rf_we = 1'b1;
          OP_LOAD: begin
            if (is_port) begin
              in_ready = 1'b1;
              rf_we    = in_valid;
              rf_wd    = in_data;
            end else if (is_dev) begin
              rf_we = 1'b1;
              rf_wd = '0;
            end else begin
              mem_rd   = 1'b1;
              mem_addr = opaddr;
            end
          end
          OP_STORE: begin
            if (is_port) out_valid = 1'b1;
            else if (!is_dev) begin
              mem_wr   = 1'b1;
              mem_addr = opaddr;
            end
          end
          OP_CALEQ, OP_CALNE: rs_we = cond;
          default: ;
        endcase
      end
      ST_LDWB: begin
        rf_we = 1'b1;
        rf_wd = mem_rdata;
      end
      default: ;
    endcase
  end

  assign out_data = rx;
  assign halted   = (st == ST_HALT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= ST_FETCH;
      ip     <= '0;
      rp     <= RP_START;
      ir     <= '0;
      opaddr <= '0;
    end else begin
      case (st)
        ST_FETCH: begin
          ip <= ip + AW'(1);
          st <= ST_OPC;
        end
        ST_OPC: begin
          ir <= mem_rdata;
          if (has_addr(mem_rdata[DW-1:DW-4])) begin
            ip <= ip + AW'(1);
            st <= ST_ADHI;
          end else begin
            st <= ST_EXEC;
          end
        end
        ST_ADHI: begin
          opaddr[AW-1:AW-DW] <= mem_rdata;
          ip <= ip + AW'(1);
          st <= ST_ADLO;
        end
        ST_ADLO: begin
          opaddr[DW-1:0] <= mem_rdata;
          st <= ST_EXEC;
        end
        ST_EXEC: begin
          st <= ST_FETCH;
          case (op)
            OP_HALT: st <= ST_HALT;
            OP_RET: begin
              ip <= rs_rdata;
              rp <= rp + AW'(1);
            end
            OP_LOAD: begin
              if (is_port) begin
                if (!in_valid) st <= ST_EXEC;
              end else if (!is_dev) begin
                st <= ST_LDWB;
              end
            end
            OP_STORE: if (is_port && !out_ready) st <= ST_EXEC;
            OP_BREQ, OP_BRNE: if (cond) ip <= opaddr;
            OP_CALEQ, OP_CALNE: begin
              if (cond) begin
                ip <= opaddr;
                rp <= rp_dec;
              end
            end
            default: ;
          endcase
        end
        ST_LDWB: st <= ST_FETCH;
        ST_HALT: st <= ST_HALT;
        default: st <= ST_FETCH;
      endcase
    end
  end

  // R12
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd && mem_wr));

  // R8
  dev_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |-> (mem_addr < DEV_BASE));

  // R11
  halt_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> (halted && !mem_rd && !mem_wr));

  // R7
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  // R6
  in_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_ready && !in_valid) |=> in_ready);

  // R10
  rp_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rp) |-> ((rp == $past(rp) + AW'(1)) || (rp == $past(rp) - AW'(1))));
endmodule

// File: tb/rc_core_tb_top.sv
module rc_core_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [15:0] mem_addr;
  logic mem_rd, mem_wr, in_ready, out_valid, halted;
  logic [7:0] mem_wdata, mem_rdata, out_data;
  logic in_valid = 1'b0, out_ready = 1'b0;
  logic [7:0] in_data = 8'h00;

  rc_core dut_i (
    .clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .halted(halted)
  );

  always #4 clk = ~clk;

  logic [7:0] mem  [0:4095];
  logic [7:0] rmem [0:4095];
  logic [7:0] in_q [0:63];
  logic [7:0] exp_q [$];
  int n_tests = 0, n_fail = 0;
  int in_idx = 0, out_idx = 0, resv_hits = 0, both_hits = 0, pc_gen = 0, model_inputs = 0;
  bit pend_take = 0, prev_stall = 0;
  logic [7:0] prev_data = 8'h00;

  // memory model: synchronous read, one cycle latency
  always @(posedge clk) begin
    if ((mem_rd || mem_wr) && mem_addr >= 16'hFFF0) resv_hits <= resv_hits + 1;
    if (mem_rd && mem_wr) both_hits <= both_hits + 1;
    if (mem_rd) mem_rdata <= mem[mem_addr[11:0]];
    if (mem_wr) mem[mem_addr[11:0]] <= mem_wdata;
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // stream drivers and monitors, acting at the falling edge
  initial begin
    forever begin
      @(negedge clk);
      if (pend_take) in_idx++;
      in_valid  = ($urandom % 100) < 50;
      in_data   = in_q[in_idx % 64];
      pend_take = in_valid && in_ready;
      if (prev_stall) chk("R7 hold while not ready", {out_valid, out_data}, {1'b1, prev_data});
      out_ready = ($urandom % 100) < 40;
      if (out_valid && out_ready) begin
        if (out_idx < exp_q.size()) chk("R7 R9 R10 output byte", out_data, exp_q[out_idx]);
        else chk("R7 extra output byte", 1, 0);
        out_idx++;
      end
      prev_stall = out_valid && !out_ready;
      prev_data  = out_data;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  // R2 encoding: opcode [7:4], X [3:2], Y [1:0]; address high byte first
  task automatic e1(int op, int x, int y);
    mem[pc_gen % 4096] = 8'((op << 4) | (x << 2) | y);
    pc_gen++;
  endtask

  task automatic e3(int op, int x, int y, int addr);
    e1(op, x, y);
    mem[pc_gen % 4096] = 8'(addr >> 8);
    pc_gen++;
    mem[pc_gen % 4096] = 8'(addr);
    pc_gen++;
  endtask

  // instruction-level reference model over rmem
  task automatic ref_run();
    logic [7:0] r [4];
    logic [15:0] rs [16];
    logic [15:0] ip, rp, a;
    logic [7:0] ins;
    int op, x, y, steps;
    bit done, take;
    ip = 0; rp = 16'hFFF0; done = 0; steps = 0; model_inputs = 0;
    for (int i = 0; i < 4; i++) r[i] = 8'h00;
    exp_q.delete();
    while (!done && steps < 5000) begin
      steps++;
      ins = rmem[ip[11:0]]; ip++;
      op = int'(ins[7:4]); x = int'(ins[3:2]); y = int'(ins[1:0]);
      a = 16'h0;
      if (op >= 10) begin
        a = {rmem[ip[11:0]], rmem[(ip + 16'd1) & 16'hFFF]};
        ip += 2;
      end
      take = (op[0]) ? (r[x] != r[y]) : (r[x] == r[y]);
      case (op)
        0: done = 1;
        1: begin ip = rs[rp[3:0]]; rp++; end
        2: r[x] = r[x] << 1;
        3: r[x] = r[x] >> 1;
        4: r[x] = {r[x][6:0], r[x][7]};
        5: r[x] = {r[x][0], r[x][7:1]};
        6: r[x] = ~(r[x] & r[y]);
        7: r[x] = r[x] & r[y];
        8: r[x] = r[x] | r[y];
        9: r[x] = r[x] ^ r[y];
        10: begin
          if (a == 16'hFFFF) begin r[x] = in_q[model_inputs % 64]; model_inputs++; end
          else if (a >= 16'hFFF0) r[x] = 8'h00;
          else r[x] = rmem[a[11:0]];
        end
        11: begin
          if (a == 16'hFFFF) exp_q.push_back(r[x]);
          else if (a < 16'hFFF0) rmem[a[11:0]] = r[x];
        end
        12, 13: if (take) ip = a;
        default: if (take) begin rp--; rs[rp[3:0]] = ip; ip = a; end
      endcase
    end
  endtask

  task automatic run_prog();
    int acc;
    @(posedge clk);
    rst_n = 1'b0;
    in_idx = 0; out_idx = 0; resv_hits = 0; both_hits = 0; pend_take = 0; prev_stall = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R1 first cycle after reset
    chk("R1 reset fetch", {mem_rd, mem_wr, halted, mem_addr}, {1'b1, 1'b0, 1'b0, 16'h0000});
    for (int c = 0; c < 20000 && !halted; c++) @(negedge clk);
    chk("R11 halted reached", halted, 1);
    acc = 0;
    repeat (8) begin
      @(negedge clk);
      if (mem_rd || mem_wr || !halted) acc++;
    end
    chk("R11 quiet after halt", acc, 0);
    chk("R8 no reserved strobe", resv_hits, 0);
    chk("R12 strobes exclusive", both_hits, 0);
    chk("R7 output count", out_idx, exp_q.size());
  endtask

  task automatic gen_random();
    int kind, x, y, t;
    for (int i = 0; i < 4096; i++) mem[i] = 8'h00;
    for (int i = 0; i < 256; i++) mem[16'h900 + i] = 8'($urandom);
    for (int i = 0; i < 64; i++) in_q[i] = 8'($urandom);
    pc_gen = 0;
    for (int i = 0; i < 4; i++) e3(10, i, 0, 16'h900 + i);
    for (int k = 0; k < 36; k++) begin
      kind = int'($urandom % 9);
      x = int'($urandom % 4);
      y = (($urandom % 4) == 0) ? x : int'($urandom % 4);
      case (kind)
        0: e3(10, x, 0, 16'h900 + int'($urandom % 256));
        1, 2: e1(2 + int'($urandom % 8), x, y);
        3: e3(11, x, 0, 16'hA00 + int'($urandom % 256));
        4: e3(11, x, 0, 16'hFFFF);
        5: e3(10, x, 0, 16'hFFFF);
        6: begin t = pc_gen + 4; e3(12 + int'($urandom % 2), x, y, t); e1(2 + int'($urandom % 8), x, y); end
        7: e3(14 + int'($urandom % 2), x, y, 16'h600);
        default: e3(10 + int'($urandom % 2), x, 0, 16'hFFF0 + int'($urandom % 15));
      endcase
    end
    e1(0, 0, 0);
    pc_gen = 16'h600;
    e1(2 + int'($urandom % 8), 1, 2);
    e3(11, 1, 0, 16'hA00 + int'($urandom % 256));
    e3(14 + int'($urandom % 2), 0, int'($urandom % 4), 16'h700);
    e3(11, 0, 0, 16'hFFFF);
    e1(1, 0, 0);
    pc_gen = 16'h700;
    e1(2 + int'($urandom % 8), 2, 3);
    e3(11, 2, 0, 16'hA00 + int'($urandom % 256));
    e1(1, 0, 0);
  endtask

  initial begin
    int miss;
    void'($urandom(32'h5EED1234));
    // directed program
    for (int i = 0; i < 4096; i++) mem[i] = 8'h00;
    mem[16'h900] = 8'h81; mem[16'h901] = 8'hC6; mem[16'h902] = 8'h5A; mem[16'hA08] = 8'h77;
    for (int i = 0; i < 64; i++) in_q[i] = 8'hE7;
    pc_gen = 0;
    e3(10, 0, 0, 16'hFFFF); e3(11, 0, 0, 16'hA09);
    for (int i = 0; i < 4; i++) e3(10, i, 0, 16'h900);
    e1(2, 0, 0); e1(3, 1, 0); e1(4, 2, 0); e1(5, 3, 0);
    for (int i = 0; i < 4; i++) e3(11, i, 0, 16'hA00 + i);
    for (int i = 0; i < 4; i++) begin
      e3(10, 0, 0, 16'h901); e3(10, 1, 0, 16'h902); e1(6 + i, 0, 1); e3(11, 0, 0, 16'hA04 + i);
    end
    e3(11, 1, 0, 16'hFFF4); e3(10, 2, 0, 16'hFFF7); e3(11, 2, 0, 16'hA08);
    e3(10, 3, 0, 16'h902);
    e3(13, 1, 3, pc_gen + 6); e3(11, 0, 0, 16'hFFFF);
    e3(12, 1, 3, pc_gen + 6); e3(11, 1, 0, 16'hFFFF);
    e3(15, 1, 1, 16'h600); e3(14, 1, 1, 16'h600);
    e1(3, 1, 0); e3(11, 1, 0, 16'hFFFF); e1(0, 0, 0);
    pc_gen = 16'h600;
    e1(2, 1, 0); e3(11, 1, 0, 16'hFFFF); e1(1, 0, 0);
    exp_q.delete();
    exp_q.push_back(8'h9C); exp_q.push_back(8'hB4); exp_q.push_back(8'h5A);
    run_prog();
    // R3 shift and rotate of 0x81
    chk("R3 SHL", mem[16'hA00], 8'h02);
    chk("R3 SHR", mem[16'hA01], 8'h40);
    chk("R3 ROL", mem[16'hA02], 8'h03);
    chk("R3 ROR", mem[16'hA03], 8'hC0);
    // R4 logic on 0xC6, 0x5A
    chk("R4 NAND", mem[16'hA04], 8'hBD);
    chk("R4 AND", mem[16'hA05], 8'h42);
    chk("R4 OR", mem[16'hA06], 8'hDE);
    chk("R4 XOR", mem[16'hA07], 8'h9C);
    chk("R8 reserved load reads zero", mem[16'hA08], 8'h00);
    chk("R6 input byte stored", mem[16'hA09], 8'hE7);
    chk("R6 one input consumed", in_idx, 1);

    // random programs checked against the model (R2 R5 R9 R10)
    for (int p = 0; p < 12; p++) begin
      gen_random();
      for (int i = 0; i < 4096; i++) rmem[i] = mem[i];
      ref_run();
      run_prog();
      miss = 0;
      for (int i = 0; i < 4096; i++) if (mem[i] !== rmem[i]) miss++;
      chk("R5 memory image mismatches", miss, 0);
      chk("R6 inputs consumed", in_idx, model_inputs);
    end
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule